// File: doc/BRIEF.md
# Store message checksum and header unit

This unit runs beside the parallel data path of a 1553 remote terminal that serves a stores interface. It follows each message word by word, from a start pulse together with the message's direction and word count. On receive, it marks the first data word as the header, folds every data word into a running checksum and judges the final word. On transmit, it forwards the words the subsystem loads and puts a generated checksum in the last word slot of the reply.

The checksum makes the XOR of all N words of a message zero, where word i (counted from 0) is first rotated right cyclically by i mod DATA_W bit positions. On transmit the checksum is emitted one cycle after the subsystem has loaded N-1 words. A word N loaded later is dropped, so the reply is identical whether the subsystem supplies N-1 or N words. On receive, `status_o` flips on each data word while the sum runs and settles on the final word: low for a good checksum, high for a bad one. A system can wire this output to block the write-back of the message and to raise a bit in the status response.

Top module: `store_cksum_unit`

## Requirements
- R1: The enable `chk_en_ni` (active low) is sampled at message start. In a disabled message, transmit words 1..N are forwarded unchanged, `status_o` stays low and `hdr_o` stays low.
- R2: A message start clears the running sum, the word index, `status_o` and `tx_vld_o` at the next edge. A word strobed in the start cycle is ignored. `word_cnt_i` = 0 encodes MAX_WORDS (32).
- R3: The checksum word C at index N-1 satisfies XOR over i of rotr(w_i, i mod DATA_W) = 0, with w_(N-1) = C.
- R4: In an enabled transmit message, each of the first N-1 loaded words appears on `tx_data_o` with `tx_vld_o` high one cycle after its strobe.
- R5: In an enabled transmit message, the checksum is output in the cycle after the (N-1)th load, or in the cycle after start when N = 1. A word loaded at position N is discarded, so exactly N words leave.
- R6: `hdr_o` is high in the same cycle as the strobe of the first accepted data word of an enabled receive message, and only then.
- R7: In an enabled receive message, `status_o` inverts one cycle after each accepted data word other than the last.
- R8: One cycle after the last receive word, `status_o` is low if R3 holds for the message and high otherwise. It holds that value until the next start.
- R9: Words strobed after all N positions are used change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_en_ni | input | 1 | Checksum enable, active low, sampled at start |
| msg_start_i | input | 1 | Message start pulse |
| tx_dir_i | input | 1 | 1 = transmit, 0 = receive; sampled at start |
| word_cnt_i | input | CNT_W | Data word count, 0 means MAX_WORDS |
| data_i | input | DATA_W | Data word on the parallel path |
| data_vld_i | input | 1 | Word strobe |
| hdr_o | output | 1 | Header word present on `data_i` |
| status_o | output | 1 | Running/final checksum status |
| tx_data_o | output | DATA_W | Outgoing transmit word |
| tx_vld_o | output | 1 | Outgoing word valid |

## Verification
A corrupted running sum shows in the transmit reply as a final word that breaks R3. On receive it shows as a wrong `status_o` one cycle after the last word. An index that is off by one shows earlier: the checksum leaves a cycle early or late, an extra word leaves, or the toggle pattern of `status_o` stops inverting at the wrong word. A bench model that rebuilds every expected word from the word queue of the message catches each of these in the cycle it first reaches a port.

// File: rtl/store_cksum_pkg.sv
package store_cksum_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/store_cksum_rot.sv
// Cyclic rotate by amt mod W; LEFT selects the direction. W must be a power of two.
module store_cksum_rot #(
  parameter int W     = 16,
  parameter int AMT_W = 6,
  parameter bit LEFT  = 1'b0
) (
  input  logic [W-1:0]     word_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     word_o
);
  localparam int SH_W = $clog2(W);

  logic [2*W-1:0] dbl;
  logic [SH_W-1:0] sh;

  assign dbl = {word_i, word_i};
  assign sh  = SH_W'(amt_i % W);

  generate
    if (LEFT) begin : g_left
      assign word_o = W'((dbl << sh) >> W);
    end else begin : g_right
      assign word_o = W'(dbl >> sh);
    end
  endgenerate
endmodule

// File: rtl/store_cksum_ctr.sv
module store_cksum_ctr #(
  parameter int MAX_WORDS = 32,
  parameter int CNT_W     = $clog2(MAX_WORDS),
  parameter int IDX_W     = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] n_o,
  output logic             first_o,
  output logic             last_o,
  output logic             nxt_last_o,
  output logic             open_o
);
  logic [IDX_W-1:0] idx_q, n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      n_q   <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
      n_q   <= (cnt_i == '0) ? IDX_W'(MAX_WORDS) : IDX_W'(cnt_i);
    end else if (fill_i) begin
      idx_q <= n_q;
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o      = idx_q;
  assign n_o        = n_q;
  assign first_o    = (idx_q == '0);
  assign last_o     = (idx_q + 1'b1 == n_q);
  assign nxt_last_o = (idx_q + 2'd2 == n_q);
  assign open_o     = (idx_q < n_q);
endmodule

// File: rtl/store_cksum_acc.sv
module store_cksum_acc #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         fold_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] acc_o,
  output logic         bad_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (fold_i) acc_q <= acc_q ^ word_i;
  end

  assign acc_o = acc_q;
  // nonzero residue once the final word is folded in
  assign bad_o = |(acc_q ^ word_i);
endmodule

// File: rtl/store_cksum_unit.sv
module store_cksum_unit
  import store_cksum_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 32,
  parameter int CNT_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_en_ni,
  input  logic              msg_start_i,
  input  logic              tx_dir_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_vld_i,
  output logic              hdr_o,
  output logic              status_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_vld_o
);
  localparam int IDX_W = CNT_W + 1;

  logic active_q, en_q, ck_pend_q, status_q, tx_vld_q;
  dir_e dir_q;
  logic [DATA_W-1:0] tx_data_q;

  logic [IDX_W-1:0] idx_w, n_w, n_m1;
  logic ctr_first, ctr_last, ctr_nxt_last, ctr_open;
  logic [DATA_W-1:0] rot_data, acc_w, ck_word;
  logic acc_bad;

  logic word_ok, is_tx, tx_fwd, rx_word, fold;

  assign is_tx   = (dir_q == DIR_TX);
  assign word_ok = data_vld_i & active_q & ctr_open & ~msg_start_i;
  // enabled transmit drops the word at the checksum slot
  assign tx_fwd  = word_ok & is_tx & (~en_q | ~ctr_last);
  assign rx_word = word_ok & en_q & ~is_tx;
  assign fold    = word_ok & en_q & ~ctr_last;
  assign n_m1    = n_w - 1'b1;

  store_cksum_ctr #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (msg_start_i),
    .cnt_i      (word_cnt_i),
    .step_i     (word_ok),
    .fill_i     (ck_pend_q),
    .idx_o      (idx_w),
    .n_o        (n_w),
    .first_o    (ctr_first),
    .last_o     (ctr_last),
    .nxt_last_o (ctr_nxt_last),
    .open_o     (ctr_open)
  );

  store_cksum_rot #(.W(DATA_W), .AMT_W(IDX_W), .LEFT(1'b0)) u_rot_in (
    .word_i (data_i),
    .amt_i  (idx_w),
    .word_o (rot_data)
  );

  store_cksum_acc #(.W(DATA_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (msg_start_i),
    .fold_i (fold),
    .word_i (rot_data),
    .acc_o  (acc_w),
    .bad_o  (acc_bad)
  );

  // undo the rotation the checksum slot will see
  store_cksum_rot #(.W(DATA_W), .AMT_W(IDX_W), .LEFT(1'b1)) u_rot_ck (
    .word_i (acc_w),
    .amt_i  (n_m1),
    .word_o (ck_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      en_q      <= 1'b0;
      dir_q     <= DIR_RX;
      ck_pend_q <= 1'b0;
      status_q  <= 1'b0;
      tx_vld_q  <= 1'b0;
      tx_data_q <= '0;
    end else if (msg_start_i) begin
      active_q  <= 1'b1;
      en_q      <= ~chk_en_ni;
      dir_q     <= dir_e'(tx_dir_i);
      ck_pend_q <= ~chk_en_ni & tx_dir_i & (word_cnt_i == CNT_W'(1));
      status_q  <= 1'b0;
      tx_vld_q  <= 1'b0;
    end else begin
      tx_vld_q <= tx_fwd | ck_pend_q;
      if (ck_pend_q)   tx_data_q <= ck_word;
      else if (tx_fwd) tx_data_q <= data_i;

      if (ck_pend_q)                           ck_pend_q <= 1'b0;
      else if (tx_fwd & en_q & ctr_nxt_last)   ck_pend_q <= 1'b1;

      if (rx_word) status_q <= ctr_last ? acc_bad : ~status_q;
    end
  end

  assign hdr_o     = rx_word & ctr_first;
  assign status_o  = status_q;
  assign tx_data_o = tx_data_q;
  assign tx_vld_o  = tx_vld_q;
endmodule

// File: rtl/store_cksum_chk.sv
module store_cksum_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_start_i,
  input logic             data_vld_i,
  input logic             hdr_o,
  input logic             status_o,
  input logic             tx_vld_o,
  input logic             is_tx,
  input logic             en_q,
  input logic             word_ok,
  input logic             ctr_last,
  input logic [IDX_W-1:0] idx_w,
  input logic [IDX_W-1:0] n_w
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_start_i |=> (!tx_vld_o && !status_o));

  a_r4_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> is_tx);

  a_r6_hdr_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_o |-> (data_vld_i && !is_tx && en_q));

  a_r6_hdr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_o |=> !hdr_o);

  a_r7_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ok && en_q && !is_tx && !ctr_last) |=> (status_o != $past(status_o)));

  a_r9_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_w <= n_w);

  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!status_o && !hdr_o));
endmodule

bind store_cksum_unit store_cksum_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_start_i (msg_start_i),
  .data_vld_i  (data_vld_i),
  .hdr_o       (hdr_o),
  .status_o    (status_o),
  .tx_vld_o    (tx_vld_o),
  .is_tx       (is_tx),
  .en_q        (en_q),
  .word_ok     (word_ok),
  .ctr_last    (ctr_last),
  .idx_w       (idx_w),
  .n_w         (n_w)
);

// File: tb/store_cksum_unit_test.sv
module store_cksum_unit_test;
  localparam int DW = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, start = 1'b0, dir = 1'b0, vld = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [DW-1:0] din = '0;
  logic hdr, status, tx_vld;
  logic [DW-1:0] tx_data;

  int n_chk = 0, n_bad = 0, cyc = 0, hdr_cnt = 0;
  bit finished = 0;
  string cur_req = "R2";
  logic [DW-1:0] cap[$];

  always #5 clk = ~clk;

  store_cksum_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .chk_en_ni(en_n), .msg_start_i(start),
    .tx_dir_i(dir), .word_cnt_i(cnt), .data_i(din), .data_vld_i(vld),
    .hdr_o(hdr), .status_o(status), .tx_data_o(tx_data), .tx_vld_o(tx_vld)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rr(logic [DW-1:0] x, int k);
    for (int j = 0; j < k; j++) x = {x[0], x[DW-1:1]};
    return x;
  endfunction

  function automatic logic [DW-1:0] rl(logic [DW-1:0] x, int k);
    for (int j = 0; j < k; j++) x = {x[DW-2:0], x[DW-1]};
    return x;
  endfunction

  // R3: word that zeroes the rotated XOR when placed after w
  function automatic logic [DW-1:0] ck_of(logic [DW-1:0] w[$]);
    logic [DW-1:0] a = '0;
    foreach (w[i]) a ^= rr(w[i], i);
    return rl(a, w.size());
  endfunction

  function automatic logic [DW-1:0] residue(logic [DW-1:0] w[$]);
    logic [DW-1:0] a = '0;
    foreach (w[i]) a ^= rr(w[i], i);
    return a;
  endfunction

  // reference model
  logic [DW-1:0] mq[$];
  int m_n = 0;
  bit m_act = 0, m_tx = 0, m_en = 0, m_pend = 0, m_done = 0;
  bit e_vld = 0, e_status = 0;
  logic [DW-1:0] e_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_act = 0; m_tx = 0; m_en = 0; m_pend = 0; m_done = 0;
      e_vld = 0; e_status = 0; e_data = '0;
    end else if (start) begin
      m_act = 1; m_tx = dir; m_en = !en_n; m_n = (cnt == 0) ? 32 : int'(cnt);
      mq.delete(); e_status = 0; e_vld = 0; m_done = 0;
      m_pend = m_en && m_tx && (m_n == 1);
    end else begin
      e_vld = 0;
      if (m_act && m_tx && m_en && m_pend) begin
        e_vld = 1; e_data = ck_of(mq); m_pend = 0; m_done = 1;
      end
      if (vld && m_act) begin
        if (m_tx && m_en) begin
          if (!m_done && mq.size() < m_n - 1) begin
            mq.push_back(din); e_vld = 1; e_data = din;
            if (mq.size() == m_n - 1) m_pend = 1;
          end
        end else if (m_tx) begin
          if (mq.size() < m_n) begin
            mq.push_back(din); e_vld = 1; e_data = din;
          end
        end else if (m_en && mq.size() < m_n) begin
          mq.push_back(din);
          if (mq.size() == m_n) e_status = (residue(mq) != '0);
          else e_status = !e_status;
        end
      end
    end
  end

  // per-cycle comparison of registered outputs
  always @(negedge clk) if (rst_n && !finished) begin
    chk(cur_req, tx_vld, e_vld);
    if (e_vld) chk(cur_req, tx_data, e_data);
    chk(cur_req == "R8" ? "R8" : "R7", status, e_status);
    if (tx_vld) cap.push_back(tx_data);
  end

  // combinational header strobe, after the inputs settle
  always @(negedge clk) if (rst_n && !finished) begin
    #2;
    chk("R6", hdr, m_act && m_en && !m_tx && vld && !start && mq.size() == 0);
    if (hdr) hdr_cnt++;
  end

  task automatic idle(int k);
    repeat (k) begin @(negedge clk); start = 0; vld = 0; end
  endtask

  task automatic start_msg(bit t, bit e, int n);
    @(negedge clk); start = 1; dir = t; en_n = !e; cnt = CW'(n); vld = 0;
  endtask

  task automatic word(logic [DW-1:0] d);
    @(negedge clk); start = 0; vld = 1; din = d;
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      summary();
    end
  end

  initial begin
    logic [DW-1:0] w[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk("R2", {tx_vld, status, hdr}, 3'b000);

    // R5: all N loaded back to back, Nth dropped
    cur_req = "R5"; cap.delete();
    start_msg(1, 1, 4);
    w = '{16'h1234, 16'h8001, 16'hbeef};
    foreach (w[i]) word(w[i]);
    word(16'hdead);
    idle(4);
    chk("R5", cap.size(), 4);
    chk("R4", cap[1], 16'h8001);
    chk("R3", residue(cap), 0);

    // R4: N-1 loaded with gaps, checksum appended
    cur_req = "R4"; cap.delete();
    start_msg(1, 1, 5);
    w = '{16'h0f0f, 16'hffff, 16'h0001, 16'ha5a5};
    foreach (w[i]) begin word(w[i]); idle(2); end
    idle(3);
    chk("R4", cap.size(), 5);
    chk("R3", residue(cap), 0);

    // R5: N = 1, then R9 extra load ignored
    cur_req = "R5"; cap.delete();
    start_msg(1, 1, 1);
    idle(3);
    word(16'h7777);
    idle(3);
    chk("R5", cap.size(), 1);
    chk("R9", cap[0], 16'h0000);

    // R8 pass, R7 toggling, R6 header, then R9 extra word
    cur_req = "R7"; hdr_cnt = 0;
    w = '{16'hc001, 16'h1357, 16'h2468, 16'hface};
    start_msg(0, 1, 5);
    foreach (w[i]) word(w[i]);
    cur_req = "R8";
    word(ck_of(w));
    idle(2);
    chk("R8", status, 0);
    chk("R6", hdr_cnt, 1);
    word(16'h0bad);
    idle(2);
    chk("R9", status, 0);

    // R8 fail
    start_msg(0, 1, 5);
    foreach (w[i]) word(w[i]);
    word(ck_of(w) ^ 16'h0100);
    idle(3);
    chk("R8", status, 1);

    // R1 disabled receive and transmit
    cur_req = "R1"; hdr_cnt = 0; cap.delete();
    start_msg(0, 0, 3);
    word(16'h1111); word(16'h2222); word(16'h3333);
    idle(2);
    chk("R1", {status, 31'(hdr_cnt)}, 0);
    start_msg(1, 0, 3);
    word(16'h1111); word(16'h2222); word(16'h3333);
    idle(2);
    chk("R1", cap.size(), 3);
    chk("R1", cap[2], 16'h3333);

    // R2: count 0 means 32
    cur_req = "R2"; cap.delete();
    start_msg(1, 1, 0);
    for (int i = 0; i < 31; i++) word(DW'(i * 977 + 3));
    idle(3);
    chk("R2", cap.size(), 32);
    chk("R3", residue(cap), 0);

    // R2: word in the start cycle ignored
    hdr_cnt = 0;
    w = '{16'h4242};
    @(negedge clk); start = 1; dir = 0; en_n = 0; cnt = 2; vld = 1; din = 16'hffff;
    word(16'h4242);
    word(ck_of(w));
    idle(2);
    chk("R2", status, 0);
    chk("R6", hdr_cnt, 1);

    idle(2);
    summary();
  end
endmodule